// File: doc/BRIEF.md
# Multi-Channel Compare Match Timer

This block is a bus-mapped timer with several independent channels. Each channel owns an up-counter, a compare register and a control/status register. A single run-enable register, shared by all channels, starts and stops each one. A channel counts on a prescaled version of a slow reference clock. The slow clock arrives as a one-cycle enable strobe in the bus clock domain.

When a channel's counter equals its compare value on a count step, the channel sets a compare-match flag. If the clear-on-match mode is set, the counter returns to zero. The match can then be routed to a level interrupt or to a one-cycle DMA request. Software reads and writes the registers over a simple synchronous bus whose read data follows the address within the same cycle. It clears status flags by read-modify-write: it writes zero to a flag bit to clear it, and a one keeps the flag as it is. A counter write is held and takes effect only after two slow-clock strobes. This matches a counter that lives in a slow domain.

Top module: `cmp_match_timer`

## Requirements
- R1: After reset every register reads zero, every channel is stopped, and `irq` and `dmaReq` are low.
- R2: The run register sits at byte address 0x00, and bit i starts (1) or stops (0) channel i. A stopped channel's counter holds its value, and starting or stopping one channel leaves the counting of the others unchanged.
- R3: Channel i's registers start at byte address 0x10 + 0x10*i, with control/status at +0, counter at +4 and compare at +8. In control/status, only bits 15, 14, 8, 7, 5:4 and 2:0 are stored; the other bits read zero. A read of an unaligned, unused or unmapped address returns zero.
- R4: Control bits 2:0 select the count rate while the channel runs. Value 4 gives one count per 8 slow strobes, 5 per 32, 6 per 128 and 7 per strobe. Values 0 to 3 do not count. The prescaler phase restarts from zero whenever the channel is stopped.
- R5: On a count step where the counter equals compare, control bit 15 (match flag) is set. With bit 8 set, the counter then goes to zero, giving a period of compare+1 counts. With bit 8 clear, it keeps incrementing.
- R6: On a count step at the all-ones value, the counter wraps to zero and control bit 14 (overflow flag) is set.
- R7: A control write with a 0 in bit 15 or bit 14 clears that flag, and a 1 leaves it unchanged. A flag set by hardware in the same cycle as a clearing write stays set.
- R8: A counter write takes effect at the second slow strobe after the write. Until then, reads return the previous counter value.
- R9: `irq[i]` is high exactly while channel i's match flag is set, bits 5:4 equal 2 and bit 7 is set.
- R10: When bits 5:4 equal 1, `dmaReq[i]` pulses high for one cycle, in the cycle after each count step that matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle strobe per slow reference clock period |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write (1) or read (0) |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the current address |
| irq | output | NUM_CH | Per-channel interrupt level |
| dmaReq | output | NUM_CH | Per-channel DMA request pulse |

## Verification
The checks assume that `slowTick` is a single-cycle strobe and that reset is held for a few cycles. They take it that counters, match flags and DMA pulses move only on a slow strobe, and that an interrupt rises only after a strobe or a bus write. The stimulus raises `slowTick` only in isolated one-cycle pulses, and between pulses it issues one bus access at a time. Only the one deliberate test of the same-cycle flag conflict places a write on a strobe cycle. Random compare values, rates and pulse counts are drawn from a fixed seed, and the expected counts are worked out from the rate rules.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int CTRL_W    = 16;
  localparam int MATCH_BIT = 15;
  localparam int OVF_BIT   = 14;
  localparam int MODE_BIT  = 8;
  localparam int IE_BIT    = 7;
  localparam int PRE_W     = 8;
  localparam logic [13:0] CFG_MASK  = 14'h01B7;
  localparam logic [1:0]  ROUTE_DMA = 2'd1;
  localparam logic [1:0]  ROUTE_IRQ = 2'd2;

  typedef struct packed {
    logic slowTick;
    logic cntTick;
    logic wrCtrl;
    logic wrCnt;
    logic wrCmp;
  } chStrobe_t;

  // slow strobes per count for a rate selection; zero means no counting
  function automatic logic [PRE_W-1:0] divLimit(input logic [2:0] sel);
    case (sel)
      3'd4:    divLimit = PRE_W'(8);
      3'd5:    divLimit = PRE_W'(32);
      3'd6:    divLimit = PRE_W'(128);
      3'd7:    divLimit = PRE_W'(1);
      default: divLimit = '0;
    endcase
  endfunction
endpackage

// File: rtl/cmpt_ctrl.sv
module cmpt_ctrl
  import cmpt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              slowTick,
  input  logic                              busSel,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [NUM_CH-1:0]                 runWdata,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]     chCtrl,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      chCnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      chCmp,
  output chStrobe_t [NUM_CH-1:0]            chStb,
  output logic [DATA_W-1:0]                 busRdata
);
  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        word;
  logic              aligned;
  logic              globalHit;
  logic [NUM_CH-1:0] runQ;

  assign blk       = busAddr[ADDR_W-1:4];
  assign word      = busAddr[3:2];
  assign aligned   = busSel && (busAddr[1:0] == 2'b00);
  assign globalHit = aligned && (blk == '0) && (word == 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN)                 runQ <= '0;
    else if (globalHit && busWr) runQ <= runWdata;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             chHit;
    logic [PRE_W-1:0] presQ;
    logic [PRE_W-1:0] limit;
    logic             lastPhase;

    assign chHit     = aligned && (blk == BLK_W'(g + 1));
    assign limit     = divLimit(chCtrl[g][2:0]);
    assign lastPhase = (limit != '0) && (presQ == limit - PRE_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN || !runQ[g])             presQ <= '0;
      else if (slowTick && limit != '0)  presQ <= lastPhase ? '0 : presQ + PRE_W'(1);
    end

    assign chStb[g] = '{slowTick: slowTick,
                        cntTick:  runQ[g] && slowTick && lastPhase,
                        wrCtrl:   chHit && busWr && (word == 2'd0),
                        wrCnt:    chHit && busWr && (word == 2'd1),
                        wrCmp:    chHit && busWr && (word == 2'd2)};
  end

  always_comb begin
    busRdata = '0;
    if (globalHit) busRdata = DATA_W'(runQ);
    for (int i = 0; i < NUM_CH; i++) begin
      if (aligned && blk == BLK_W'(i + 1)) begin
        case (word)
          2'd0:    busRdata = DATA_W'(chCtrl[i]);
          2'd1:    busRdata = DATA_W'(chCnt[i]);
          2'd2:    busRdata = DATA_W'(chCmp[i]);
          default: busRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmpt_chan.sv
module cmpt_chan
  import cmpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic [CNT_W-1:0]  cmpQ,
  output logic              irq,
  output logic              dmaReq
);
  logic [13:0]      cfgQ;
  logic             matchQ;
  logic             ovfQ;
  logic [CNT_W-1:0] pendQ;
  logic [1:0]       pendCntQ;
  logic             atCmp;
  logic             matchHit;
  logic             wrapHit;
  logic             loadNow;
  logic [1:0]       route;

  assign route    = cfgQ[5:4];
  assign atCmp    = (cntQ == cmpQ);
  assign matchHit = stb.cntTick && atCmp;
  assign wrapHit  = stb.cntTick && (&cntQ);
  assign loadNow  = stb.slowTick && (pendCntQ == 2'd1) && !stb.wrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ     <= '0;
      matchQ   <= 1'b0;
      ovfQ     <= 1'b0;
      cntQ     <= '0;
      cmpQ     <= '0;
      pendQ    <= '0;
      pendCntQ <= '0;
      dmaReq   <= 1'b0;
    end else begin
      if (stb.wrCmp) cmpQ <= wdata[CNT_W-1:0];
      if (stb.wrCtrl) cfgQ <= wdata[13:0] & CFG_MASK;

      if (stb.wrCnt) begin
        pendQ    <= wdata[CNT_W-1:0];
        pendCntQ <= 2'd2;
      end else if (stb.slowTick && pendCntQ != 2'd0) begin
        pendCntQ <= pendCntQ - 2'd1;
      end

      if (loadNow)          cntQ <= pendQ;
      else if (stb.cntTick) cntQ <= (cfgQ[MODE_BIT] && atCmp) ? '0 : cntQ + 1'b1;

      matchQ <= matchHit | (matchQ & ~(stb.wrCtrl & ~wdata[MATCH_BIT]));
      ovfQ   <= wrapHit  | (ovfQ   & ~(stb.wrCtrl & ~wdata[OVF_BIT]));
      dmaReq <= matchHit && (route == ROUTE_DMA);
    end
  end

  assign ctrlQ = {matchQ, ovfQ, cfgQ};
  assign irq   = matchQ && (route == ROUTE_IRQ) && cfgQ[IE_BIT];
endmodule

// File: rtl/cmp_match_timer.sv
module cmp_match_timer
  import cmpt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] dmaReq
);
  chStrobe_t [NUM_CH-1:0]          chStb;
  logic [NUM_CH-1:0][CTRL_W-1:0]   chCtrl;
  logic [NUM_CH-1:0][CNT_W-1:0]    chCnt;
  logic [NUM_CH-1:0][CNT_W-1:0]    chCmp;
  logic [NUM_CH-1:0]               tickVec;
  logic [NUM_CH-1:0]               matchVec;

  cmpt_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .runWdata(busWdata[NUM_CH-1:0]), .chCtrl(chCtrl),
    .chCnt(chCnt), .chCmp(chCmp), .chStb(chStb), .busRdata(busRdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    cmpt_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
      .clk(clk), .rstN(rstN), .stb(chStb[g]), .wdata(busWdata),
      .ctrlQ(chCtrl[g]), .cntQ(chCnt[g]), .cmpQ(chCmp[g]),
      .irq(irq[g]), .dmaReq(dmaReq[g])
    );
    assign tickVec[g]  = chStb[g].cntTick;
    assign matchVec[g] = chCtrl[g][MATCH_BIT];
  end
endmodule

// File: rtl/cmp_match_timer_chk.sv
module cmp_match_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         slowTick,
  input logic                         busSel,
  input logic                         busWr,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0]            dmaReq,
  input logic [NUM_CH-1:0]            tickVec,
  input logic [NUM_CH-1:0]            matchVec,
  input logic [NUM_CH-1:0][CNT_W-1:0] chCnt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (irq == '0 && dmaReq == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R4
    tick_needs_slow_chk: assert property (@(posedge clk) disable iff (!rstN)
      tickVec[g] |-> slowTick);
    // R2
    cnt_moves_on_slow_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(chCnt[g]) |-> $past(slowTick));
    // R5
    match_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(matchVec[g]) |-> $past(slowTick));
    // R10
    dma_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
      dmaReq[g] |-> $past(tickVec[g]));
    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[g]) |-> $past(slowTick || (busSel && busWr)));
  end
endmodule

bind cmp_match_timer cmp_match_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .busSel(busSel), .busWr(busWr),
  .irq(irq), .dmaReq(dmaReq), .tickVec(tickVec), .matchVec(matchVec), .chCnt(chCnt)
);

// File: tb/cmp_match_timer_bench.sv
module cmp_match_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irq;
  logic [1:0]  dmaReq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  cmp_match_timer u_cmp_match_timer (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .dmaReq(dmaReq)
  );

  function automatic logic [7:0] chA(input int ch, input int off);
    return 8'(16 + ch * 16 + off);
  endfunction

  function automatic int expCount(input int sel, input int p);
    case (sel)
      4: return p / 8;
      5: return p / 32;
      6: return p / 128;
      7: return p;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slowTick = 1'b1;
      @(negedge clk); slowTick = 1'b0;
    end
  endtask

  task automatic loadCnt(input int ch, input logic [31:0] v);
    wr(chA(ch, 4), v);
    pulse(2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] cA, cB, oldV, newV;
    int n, m, q, p, c, hits, bad, lowBad, sel;
    v = $urandom(32'h5EED1234);
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, v); check("R1 run reg", v, 0);
    for (int ch = 0; ch < 2; ch++)
      for (int o = 0; o < 12; o += 4) begin
        rd(chA(ch, o), v); check("R1 channel reg", v, 0);
      end
    check("R1 irq", 32'(irq), 0);
    check("R1 dmaReq", 32'(dmaReq), 0);

    // R3 map and stored bits
    wr(chA(1, 0), 32'hFFFF);
    rd(chA(1, 0), v); check("R3 ctrl mask", v, 32'h01B7);
    cA = $urandom; cB = $urandom;
    wr(chA(0, 8), cA); wr(chA(1, 8), cB);
    rd(chA(0, 8), v); check("R3 cmp ch0", v, cA);
    rd(chA(1, 8), v); check("R3 cmp ch1", v, cB);
    rd(chA(0, 12), v); check("R3 unused word", v, 0);
    rd(8'h04, v); check("R3 global unused", v, 0);
    rd(chA(0, 9), v); check("R3 unaligned", v, 0);
    rd(chA(2, 0), v); check("R3 unmapped block", v, 0);
    wr(chA(1, 0), 32'h0);

    // R2 run register independence
    wr(chA(0, 0), 32'h0007);
    wr(8'h00, 32'h1);
    n = 5 + int'($urandom % 16);
    pulse(n);
    rd(chA(0, 4), v); check("R2 ch0 runs", v, 32'(n));
    rd(chA(1, 4), v); check("R2 ch1 held", v, 0);
    rd(8'h00, v); check("R2 run readback", v, 1);
    wr(chA(1, 0), 32'h0004);
    wr(8'h00, 32'h3);
    m = 8 + int'($urandom % 40);
    pulse(m);
    rd(chA(0, 4), v); check("R2 ch0 continues", v, 32'(n + m));
    rd(chA(1, 4), v); check("R2 R4 ch1 div8", v, 32'(m / 8));
    wr(8'h00, 32'h2);
    q = 16;
    pulse(q);
    rd(chA(0, 4), v); check("R2 ch0 stopped holds", v, 32'(n + m));
    rd(chA(1, 4), v); check("R2 ch1 unaffected", v, 32'((m + q) / 8));
    wr(8'h00, 32'h0);
    oldV = 32'(n + m);

    // R4 every rate selection
    for (int s = 0; s < 8; s++) begin
      wr(chA(1, 0), 32'(s));
      loadCnt(1, 0);
      wr(8'h00, 32'h2);
      p = int'($urandom % 300);
      pulse(p);
      rd(chA(1, 4), v); check($sformatf("R4 sel %0d", s), v, 32'(expCount(s, p)));
      wr(8'h00, 32'h0);
    end

    // R8 delayed counter write
    newV = $urandom;
    wr(chA(0, 4), newV);
    rd(chA(0, 4), v); check("R8 old after write", v, oldV);
    pulse(1);
    rd(chA(0, 4), v); check("R8 old after one strobe", v, oldV);
    pulse(1);
    rd(chA(0, 4), v); check("R8 new after two strobes", v, newV);

    // R5 clear-on-match period
    c = 3 + int'($urandom % 14);
    wr(chA(0, 0), 32'h0107);
    wr(chA(0, 8), 32'(c));
    loadCnt(0, 0);
    wr(8'h00, 32'h1);
    pulse(c);
    rd(chA(0, 4), v); check("R5 reaches compare", v, 32'(c));
    rd(chA(0, 0), v); check("R5 no flag yet", v, 32'h0107);
    pulse(1);
    rd(chA(0, 4), v); check("R5 cleared on match", v, 0);
    rd(chA(0, 0), v); check("R5 flag set", v, 32'h8107);
    pulse(c + 1);
    rd(chA(0, 4), v); check("R5 period compare+1", v, 0);
    wr(8'h00, 32'h0);
    // R5 free-running
    wr(chA(1, 0), 32'h0007);
    wr(chA(1, 8), 32'(c));
    loadCnt(1, 0);
    wr(8'h00, 32'h2);
    pulse(c + 3);
    rd(chA(1, 4), v); check("R5 free-run passes compare", v, 32'(c + 3));
    rd(chA(1, 0), v); check("R5 free-run flag", v, 32'h8007);
    wr(8'h00, 32'h0);

    // R7 flag write semantics
    wr(chA(0, 0), 32'hC1A7);
    rd(chA(0, 0), v); check("R7 writing one keeps flag", v, 32'h81A7);
    check("R9 irq on", 32'(irq[0]), 1);
    wr(chA(0, 0), 32'h4127);
    rd(chA(0, 0), v); check("R7 writing zero clears", v, 32'h0127);
    check("R9 irq off after clear", 32'(irq[0]), 0);
    // R7 hardware set wins over clear
    wr(chA(0, 8), 32'h0);
    loadCnt(0, 0);
    wr(8'h00, 32'h1);
    @(negedge clk);
    slowTick = 1'b1; busSel = 1'b1; busWr = 1'b1; busAddr = chA(0, 0); busWdata = 32'h0107;
    @(negedge clk);
    slowTick = 1'b0; busSel = 1'b0; busWr = 1'b0;
    rd(chA(0, 0), v); check("R7 set wins", v, 32'h8107);
    wr(8'h00, 32'h0);

    // R9 interrupt gating
    wr(chA(0, 0), 32'h81A7); check("R9 route2 ie", 32'(irq[0]), 1);
    wr(chA(0, 0), 32'h8197); check("R9 route1 no irq", 32'(irq[0]), 0);
    wr(chA(0, 0), 32'h8127); check("R9 ie clear no irq", 32'(irq[0]), 0);
    wr(chA(0, 0), 32'h81A7); check("R9 re-enabled", 32'(irq[0]), 1);
    wr(chA(0, 0), 32'h01A7); check("R9 flag cleared", 32'(irq[0]), 0);

    // R6 overflow
    wr(chA(1, 0), 32'h0007);
    wr(chA(1, 8), 32'h5);
    loadCnt(1, 32'hFFFF_FFFE);
    wr(8'h00, 32'h2);
    pulse(1);
    rd(chA(1, 4), v); check("R6 at max", v, 32'hFFFF_FFFF);
    rd(chA(1, 0), v); check("R6 no ovf yet", v, 32'h0007);
    pulse(1);
    rd(chA(1, 4), v); check("R6 wrapped", v, 0);
    rd(chA(1, 0), v); check("R6 ovf set", v, 32'h4007);
    wr(chA(1, 0), 32'h0007);
    rd(chA(1, 0), v); check("R6 R7 ovf cleared", v, 32'h0007);
    wr(8'h00, 32'h0);

    // R10 DMA pulses
    c = 2 + int'($urandom % 6);
    wr(chA(0, 0), 32'h0117);
    wr(chA(0, 8), 32'(c));
    loadCnt(0, 0);
    wr(8'h00, 32'h1);
    hits = 0; bad = 0; lowBad = 0;
    for (int k = 1; k <= 3 * (c + 1); k++) begin
      @(negedge clk);
      if (dmaReq[0]) lowBad++;
      slowTick = 1'b1;
      @(negedge clk);
      slowTick = 1'b0;
      if (dmaReq[0]) hits++;
      if (dmaReq[0] !== ((k % (c + 1)) == 0)) bad++;
      if (dmaReq[1]) bad++;
    end
    @(negedge clk);
    if (dmaReq[0]) lowBad++;
    check("R10 pulse count", 32'(hits), 3);
    check("R10 pulse position", 32'(bad), 0);
    check("R10 single cycle", 32'(lowBad), 0);
    wr(8'h00, 32'h0);

    // R4 R5 random rounds
    for (int r = 0; r < 6; r++) begin
      sel = 4 + int'($urandom % 4);
      c = int'($urandom % 16);
      p = int'($urandom % 400);
      wr(chA(1, 0), 32'(32'h0100 | sel));
      wr(chA(1, 8), 32'(c));
      loadCnt(1, 0);
      wr(8'h00, 32'h2);
      pulse(p);
      n = expCount(sel, p);
      rd(chA(1, 4), v); check("R4 R5 random count", v, 32'(n % (c + 1)));
      rd(chA(1, 0), v);
      check("R5 random flag", v, (n > c ? 32'h8000 : 32'h0) | 32'h0100 | 32'(sel));
      wr(8'h00, 32'h0);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule